// File: doc/BRIEF.md
# Single-Cell Charge Phase Sequencer

This block sequences a single lithium-ion cell through a complete charge cycle. It works from comparator flags that are already digital: battery below the short level, battery below the low-voltage level, battery at regulation, current below the termination level, current below the tracking-end level, and the recharge level crossed. A two-bit temperature zone code also feeds it. From these flags the block selects a current setpoint and a rectifier voltage target for the analog loops. It also enables the charger output, drives a charge-status line, and raises a termination request toward the packet sender.

The charger output stays off until the rectifier has converged on its no-load target. After that, the block steps through the phases in order: short-circuit recovery, precharge at one fifth of bulk current, constant current, constant voltage, and done. Moves between precharge and constant current in either direction are deglitched in ticks. A precharge timer and a fast-charge timer guard the cycle; if either expires, the block latches a fault that only a reset clears. Every timer counts a 1 ms tick input, so a simulation can compress time by ticking faster.

Top module: `chg_phase_ctrl`

## Requirements
- R1: After reset, `out_en`, `chg_stat`, `rect_track` and `vreg_low` are 0 and `iset_sel` and `term_req` are 0. The block stays in this waiting state for as long as `rect_conv` is low.
- R2: When `rect_conv` is high in the waiting state, the next state depends on the battery flags. It is recovery (`iset_sel`=1) if `bat_short` is high, precharge (`iset_sel`=2, 20 % of bulk) if only `bat_low` is high, and constant current (`iset_sel`=3, bulk) otherwise.
- R3: Recovery moves to precharge on the first clock with `bat_short` low. Precharge moves back to recovery on the first clock with `bat_short` high.
- R4: Precharge moves to constant current only after `bat_low` has been low on DGL_TICKS consecutive ticks. Constant current moves back to precharge only after `bat_low` has been high on DGL_TICKS consecutive ticks. Any clock on which the condition lapses restarts the count.
- R5: Ticks spent in recovery plus precharge are counted. When the count reaches PRE_TMO_TICKS, the block enters the fault state. The count clears whenever the block is in any other state.
- R6: Ticks spent in constant current plus constant voltage are counted. When the count reaches FAST_TMO_TICKS, the block enters the fault state.
- R7: The fault state drives `term_req`=2 and keeps the output off. No input other than reset makes the block leave it.
- R8: Constant current moves to constant voltage when `bat_at_reg` is high; this takes priority over the deglitched return to precharge. Constant voltage moves to done when `ibat_below_term` is high. Done drives `term_req`=1 with the output off.
- R9: In done, a high `recharge` restarts the cycle in constant current, and the fast-charge count starts again from zero.
- R10: `rect_track` is 1 (target equals battery plus 300 mV) only when all of the following hold: the output is enabled, `bat_low` is low, and the block is either in constant current or in constant voltage with `ibat_below_track` low. In every other case `rect_track` is 0 (fixed regulation target).
- R11: `out_en` is high in recovery, precharge, constant current and constant voltage unless the zone is 3. `chg_stat` always equals `out_en`.
- R12: Zone codes work as follows. Zone 0 is normal. Zone 1 halves the bulk setpoint (`iset_sel`=4) in constant current and constant voltage. Zone 2 does the same and also sets `vreg_low`. Zone 3 in an active phase turns the output off (`iset_sel`=0) and freezes the state, the timers and any deglitch count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond time base |
| rect_conv | input | 1 | Rectifier has converged on the no-load target |
| bat_short | input | 1 | Battery below the short-circuit level |
| bat_low | input | 1 | Battery below the low-voltage level |
| bat_at_reg | input | 1 | Battery at regulation voltage |
| ibat_below_term | input | 1 | Charge current below termination level |
| ibat_below_track | input | 1 | Charge current below the tracking-end fraction of bulk |
| recharge | input | 1 | Battery fell below the recharge level |
| temp_zone | input | 2 | Temperature zone: 0 normal, 1 cool, 2 warm, 3 out of range |
| iset_sel | output | 3 | Current setpoint: 0 off, 1 recovery, 2 precharge, 3 bulk, 4 half bulk |
| rect_track | output | 1 | 1 tracks battery plus offset, 0 fixed rectifier target |
| out_en | output | 1 | Charger output enable |
| chg_stat | output | 1 | Charge status, follows the output enable |
| vreg_low | output | 1 | Reduced regulation voltage in the warm zone |
| term_req | output | 2 | Termination request: 0 none, 1 charge complete, 2 fault |

## Verification
The bench targets four corner cases.

- **Deglitch counts.** It feeds deglitch windows that lapse one tick short and windows that finish exactly on the limit. A sequencer that does not restart its count on a lapse would reach fast charge too early. One that is off by one tick would switch a tick late or early.
- **Freeze in zone 3.** It parks the block in zone 3 partway through a precharge timeout. A design that kept counting there would fault too early; one that cleared the count would fault too late.
- **Done and fault states.** It checks that done rearms the fast-charge timer from zero and that a fault ignores `recharge` and every battery flag. It also checks that `bat_at_reg` wins over a deglitched return to precharge when both arrive together.
- **Random stress.** A long random run with periodic resets compares every output on every cycle.

// File: rtl/chg_phase_pkg.sv
package chg_phase_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_RECOV = 3'd1,
    ST_PRE   = 3'd2,
    ST_CC    = 3'd3,
    ST_CV    = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } chg_st_e;

  localparam logic [2:0] ISET_OFF   = 3'd0;
  localparam logic [2:0] ISET_RECOV = 3'd1;
  localparam logic [2:0] ISET_PRE   = 3'd2;
  localparam logic [2:0] ISET_BULK  = 3'd3;
  localparam logic [2:0] ISET_HALF  = 3'd4;

  localparam logic [1:0] TERM_NONE  = 2'd0;
  localparam logic [1:0] TERM_DONE  = 2'd1;
  localparam logic [1:0] TERM_FAULT = 2'd2;

  localparam logic [1:0] ZONE_NORM = 2'd0;
  localparam logic [1:0] ZONE_COOL = 2'd1;
  localparam logic [1:0] ZONE_WARM = 2'd2;
  localparam logic [1:0] ZONE_OUT  = 2'd3;

  // Phases in which the charger path carries current
  function automatic logic is_active(chg_st_e st);
    return (st == ST_RECOV) || (st == ST_PRE) || (st == ST_CC) || (st == ST_CV);
  endfunction

  // Phases guarded by the precharge timer
  function automatic logic in_pre_region(chg_st_e st);
    return (st == ST_RECOV) || (st == ST_PRE);
  endfunction

  // Phases guarded by the fast-charge timer
  function automatic logic in_fast_region(chg_st_e st);
    return (st == ST_CC) || (st == ST_CV);
  endfunction

  function automatic logic [2:0] iset_code(chg_st_e st, logic [1:0] zone);
    case (st)
      ST_RECOV:     return ISET_RECOV;
      ST_PRE:       return ISET_PRE;
      ST_CC, ST_CV: return (zone == ZONE_NORM) ? ISET_BULK : ISET_HALF;
      default:      return ISET_OFF;
    endcase
  endfunction

  function automatic logic [1:0] term_code(chg_st_e st);
    case (st)
      ST_DONE:  return TERM_DONE;
      ST_FAULT: return TERM_FAULT;
      default:  return TERM_NONE;
    endcase
  endfunction

endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
  parameter int unsigned LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // Fires on the tick that completes LIMIT counted ticks
  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/chg_out_decode.sv
module chg_out_decode
  import chg_phase_pkg::*;
(
  input  chg_st_e    st,
  input  logic [1:0] zone,
  input  logic       bat_low,
  input  logic       below_track,
  output logic [2:0] iset_sel,
  output logic       rect_track,
  output logic       out_en,
  output logic       chg_stat,
  output logic       vreg_low,
  output logic [1:0] term_req
);
  always_comb begin
    out_en     = is_active(st) && (zone != ZONE_OUT);
    chg_stat   = out_en;
    iset_sel   = out_en ? iset_code(st, zone) : ISET_OFF;
    rect_track = out_en && !bat_low &&
                 ((st == ST_CC) || ((st == ST_CV) && !below_track));
    vreg_low   = out_en && in_fast_region(st) && (zone == ZONE_WARM);
    term_req   = term_code(st);
  end
endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl
  import chg_phase_pkg::*;
#(
  parameter int unsigned DGL_TICKS      = 25,
  parameter int unsigned PRE_TMO_TICKS  = 1_800_000,
  parameter int unsigned FAST_TMO_TICKS = 36_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       rect_conv,
  input  logic       bat_short,
  input  logic       bat_low,
  input  logic       bat_at_reg,
  input  logic       ibat_below_term,
  input  logic       ibat_below_track,
  input  logic       recharge,
  input  logic [1:0] temp_zone,
  output logic [2:0] iset_sel,
  output logic       rect_track,
  output logic       out_en,
  output logic       chg_stat,
  output logic       vreg_low,
  output logic [1:0] term_req
);

  chg_st_e st_q, st_d;

  // Named internal events
  logic susp;
  logic dgl_cond, dgl_hit;
  logic pre_hit, fast_hit;

  assign susp     = is_active(st_q) && (temp_zone == ZONE_OUT);
  assign dgl_cond = ((st_q == ST_PRE) && !bat_low && !bat_short) ||
                    ((st_q == ST_CC) && bat_low);

  chg_tick_timer #(.LIMIT(DGL_TICKS)) u_dgl (
    .clk(clk), .rst_n(rst_n),
    .clr(!dgl_cond),
    .run(tick_1ms && dgl_cond && !susp),
    .hit(dgl_hit)
  );

  chg_tick_timer #(.LIMIT(PRE_TMO_TICKS)) u_pre_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(!in_pre_region(st_q)),
    .run(tick_1ms && in_pre_region(st_q) && !susp),
    .hit(pre_hit)
  );

  chg_tick_timer #(.LIMIT(FAST_TMO_TICKS)) u_fast_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(!in_fast_region(st_q)),
    .run(tick_1ms && in_fast_region(st_q) && !susp),
    .hit(fast_hit)
  );

  always_comb begin
    st_d = st_q;
    if (!susp) begin
      case (st_q)
        ST_WAIT:
          if (rect_conv)
            st_d = bat_short ? ST_RECOV : (bat_low ? ST_PRE : ST_CC);
        ST_RECOV:
          if (pre_hit)         st_d = ST_FAULT;
          else if (!bat_short) st_d = ST_PRE;
        ST_PRE:
          if (pre_hit)         st_d = ST_FAULT;
          else if (bat_short)  st_d = ST_RECOV;
          else if (dgl_hit)    st_d = ST_CC;
        ST_CC:
          if (fast_hit)        st_d = ST_FAULT;
          else if (bat_at_reg) st_d = ST_CV;
          else if (dgl_hit)    st_d = ST_PRE;
        ST_CV:
          if (fast_hit)             st_d = ST_FAULT;
          else if (ibat_below_term) st_d = ST_DONE;
        ST_DONE:
          if (recharge)        st_d = ST_CC;
        ST_FAULT:              st_d = ST_FAULT;
        default:               st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT;
    else        st_q <= st_d;
  end

  chg_out_decode u_dec (
    .st(st_q), .zone(temp_zone), .bat_low(bat_low), .below_track(ibat_below_track),
    .iset_sel(iset_sel), .rect_track(rect_track), .out_en(out_en),
    .chg_stat(chg_stat), .vreg_low(vreg_low), .term_req(term_req)
  );

  assert_wait_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !rect_conv) |=> (st_q == ST_WAIT));

  assert_dgl_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CC && $past(st_q) == ST_PRE) |-> $past(dgl_hit));

  assert_fault_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT) |=> (st_q == ST_FAULT));

  assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && $past(st_q) == ST_CV) |-> $past(ibat_below_term));

  assert_term_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req != TERM_NONE) |-> !out_en);

  assert_susp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(st_q));

endmodule

// File: tb/test_chg_phase_ctrl.sv
module test_chg_phase_ctrl;
  localparam int DGL = 4, PRE_T = 50, FAST_T = 80;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, rect_conv = 1'b0, bat_short = 1'b0, bat_low = 1'b0;
  logic bat_at_reg = 1'b0, below_term = 1'b0, below_track = 1'b0, recharge = 1'b0;
  logic [1:0] zone = 2'd0;
  logic [2:0] iset_sel;
  logic rect_track, out_en, chg_stat, vreg_low;
  logic [1:0] term_req;

  chg_phase_ctrl #(.DGL_TICKS(DGL), .PRE_TMO_TICKS(PRE_T), .FAST_TMO_TICKS(FAST_T))
  i_chg_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .rect_conv(rect_conv),
    .bat_short(bat_short), .bat_low(bat_low), .bat_at_reg(bat_at_reg),
    .ibat_below_term(below_term), .ibat_below_track(below_track),
    .recharge(recharge), .temp_zone(zone),
    .iset_sel(iset_sel), .rect_track(rect_track), .out_en(out_en),
    .chg_stat(chg_stat), .vreg_low(vreg_low), .term_req(term_req)
  );

  // Reference model: 0 wait,1 recovery,2 precharge,3 cc,4 cv,5 done,6 fault
  int m_st = 0, dgl_n = 0, pre_n = 0, fast_n = 0;
  int vectors = 0, miscompares = 0;
  string req = "R1";
  bit finished = 0;

  always @(posedge clk or negedge rst_n) begin
    bit act, frz, want, go_dgl, pexp, fexp;
    int nx;
    if (!rst_n) begin
      m_st = 0; dgl_n = 0; pre_n = 0; fast_n = 0;
    end else begin
      act  = (m_st >= 1 && m_st <= 4);
      frz  = act && (zone == 2'd3);
      want = (m_st == 2 && !bat_low && !bat_short) || (m_st == 3 && bat_low);
      go_dgl = 0; pexp = 0; fexp = 0;
      if (!want) dgl_n = 0;
      else if (tick && !frz) begin
        dgl_n++;
        if (dgl_n == DGL) begin go_dgl = 1; dgl_n = 0; end
      end
      if (!(m_st == 1 || m_st == 2)) pre_n = 0;
      else if (tick && !frz) begin
        pre_n++;
        if (pre_n == PRE_T) begin pexp = 1; pre_n = 0; end
      end
      if (!(m_st == 3 || m_st == 4)) fast_n = 0;
      else if (tick && !frz) begin
        fast_n++;
        if (fast_n == FAST_T) begin fexp = 1; fast_n = 0; end
      end
      nx = m_st;
      if (!frz) begin
        case (m_st)
          0: if (rect_conv) nx = bat_short ? 1 : (bat_low ? 2 : 3);
          1: nx = pexp ? 6 : (!bat_short ? 2 : 1);
          2: nx = pexp ? 6 : (bat_short ? 1 : (go_dgl ? 3 : 2));
          3: nx = fexp ? 6 : (bat_at_reg ? 4 : (go_dgl ? 2 : 3));
          4: nx = fexp ? 6 : (below_term ? 5 : 4);
          5: nx = recharge ? 3 : 5;
          default: nx = 6;
        endcase
      end
      m_st = nx;
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    bit en;
    logic [2:0] e_iset;
    logic e_rect, e_vlow;
    logic [1:0] e_term;
    logic [8:0] exp_v, act_v;
    #2;
    if (!finished) begin
      en     = (m_st >= 1 && m_st <= 4) && (zone != 2'd3);
      e_iset = !en ? 3'd0 : (m_st == 1) ? 3'd1 : (m_st == 2) ? 3'd2 :
               (zone == 2'd0) ? 3'd3 : 3'd4;
      e_rect = en && !bat_low && (m_st == 3 || (m_st == 4 && !below_track));
      e_vlow = en && (m_st == 3 || m_st == 4) && (zone == 2'd2);
      e_term = (m_st == 5) ? 2'd1 : (m_st == 6) ? 2'd2 : 2'd0;
      exp_v  = {e_iset, e_rect, en, en, e_vlow, e_term};
      act_v  = {iset_sel, rect_track, out_en, chg_stat, vreg_low, term_req};
      vectors++;
      if (act_v !== exp_v) begin
        miscompares++;
        $display("FAIL %s t=%0t outputs act=%b exp=%b (model state %0d)",
                 req, $time, act_v, exp_v, m_st);
      end
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ~tick;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run(3); rst_n = 1'b1;
  endtask

  initial begin
    // R1: reset state and waiting for rectifier convergence
    req = "R1";
    run(3); rst_n = 1'b1;
    run(6);
    // R2: entry on convergence with a shorted battery
    req = "R2";
    bat_short = 1; bat_low = 1; rect_conv = 1; run(3);
    // R3: recovery <-> precharge follow the short flag at once
    req = "R3";
    bat_short = 0; run(3);
    bat_short = 1; run(2);
    bat_short = 0; run(2);
    // R4: lapsed window, then a full window into constant current
    req = "R4";
    bat_low = 0; run(5);
    bat_low = 1; run(2);
    bat_low = 0; run(12);
    // R12: zone handling in constant current
    req = "R12";
    zone = 2'd1; run(4);
    zone = 2'd2; run(4);
    zone = 2'd3; bat_low = 1; run(10);
    zone = 2'd0; bat_low = 0; run(2);
    // R4: deglitched return to precharge and back
    req = "R4";
    bat_low = 1; run(12);
    bat_low = 0; run(12);
    // R10: rectifier target tracking and the end of tracking
    req = "R10";
    bat_at_reg = 1; bat_low = 1; run(3);
    bat_low = 0; run(3);
    below_track = 1; run(3);
    // R8: termination
    req = "R8";
    below_term = 1; run(3);
    below_term = 0; below_track = 0; bat_at_reg = 0; run(3);
    // R9: recharge restarts at constant current
    req = "R9";
    recharge = 1; run(2);
    recharge = 0; run(4);
    // R6: fast-charge timeout
    req = "R6";
    run(200);
    // R7: fault ignores every input but reset
    req = "R7";
    recharge = 1; bat_short = 1; bat_at_reg = 1; run(10);
    recharge = 0; bat_short = 0; bat_at_reg = 0; run(10);
    // R5: precharge timeout
    req = "R5";
    do_reset(); bat_low = 1; run(120);
    // R12: zone 3 freezes the precharge timer
    req = "R12";
    do_reset(); run(40);
    zone = 2'd3; run(100);
    zone = 2'd0; run(80);
    // R11: random stress of all flags and zones
    req = "R11";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (c % 400 == 0) rst_n = 1'b0;
      else if (c % 400 == 2) rst_n = 1'b1;
      tick = ($urandom % 3) == 0;
      if ($urandom % 40 == 0) rect_conv = ~rect_conv;
      if ($urandom % 30 == 0) bat_short = ~bat_short;
      if ($urandom % 12 == 0) bat_low = ~bat_low;
      if ($urandom % 15 == 0) bat_at_reg = ~bat_at_reg;
      if ($urandom % 15 == 0) below_term = ~below_term;
      if ($urandom % 10 == 0) below_track = ~below_track;
      if ($urandom % 20 == 0) recharge = ~recharge;
      if ($urandom % 25 == 0) zone = 2'($urandom % 4);
    end
    run(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule